// File: doc/BRIEF.md
# Run-Length Parity Violation Detector

This block watches a serial bit stream that arrives one bit per clock whenever a valid strobe is high. The stream is legal only when every maximal run of zeros has even length and every maximal run of ones has odd length. The detector learns that a run was illegal on the bit that closes it, that is, the first bit of the opposite symbol. It then raises a single-cycle violation flag on the clock after that bit.

Internally the detector is a reduced Mealy machine with four states held in a 2-bit register. The machine tracks two things: which symbol the current run is made of, and whether the run length so far is odd or even. The "no bits yet" condition and the "even run of zeros" condition behave the same for every future input, so they share one state. The current state code is brought out on a debug port.

A run that is still open when the stream pauses or stops is never judged. Only a boundary between two runs can produce a flag.

Top module: `runpar_detector`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `state_code` = 2'b00 and `viol` = 0.
- R2: `state_code` uses this encoding: 2'b00 means no bits seen since reset, or the current zero run has even length. 2'b01 means the zero run has odd length. 2'b10 means the one run has odd length. 2'b11 means the one run has even length. The code is updated on the clock edge that accepts a bit.
- R3: An accepted 1 that follows a zero run of odd length raises `viol` in the cycle after that bit.
- R4: An accepted 0 that follows a one run of even length raises `viol` in the cycle after that bit.
- R5: A run boundary that closes a legal run (an even zero run or an odd one run) leaves `viol` at 0.
- R6: A bit that extends the current run, or the first bit after reset, never raises `viol`.
- R7: When `din_vld` is low at an edge, `state_code` keeps its value and `viol` is 0 in the following cycle.
- R8: `viol` is a registered pulse. It is high only in the single cycle after the violating bit, unless the next accepted bit is itself a violation.
- R9: A run that is open when the stream pauses is never flagged. A reset in the middle of a run discards that run, so the next bit starts fresh without a flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data bit |
| din_vld | input | 1 | High when `din` carries a bit to accept |
| viol | output | 1 | One-cycle flag for a run that ended with the wrong parity |
| state_code | output | 2 | Debug view of the current machine state |

## Verification
Closing one run and opening the next always happen on the same accepted bit. A single edge must therefore both judge the old run's parity and set up the new run with a length of one. The bench provokes this with alternating runs of length 1 through 4 of each symbol, including back-to-back single bits and runs that end in a violation immediately after another violation. A behavioural run-length counter judges every such edge, comparing both the flag and the new state code on the following cycle. Random streams with gaps in `din_vld` also place boundaries directly after held cycles.

// File: rtl/runpar_pkg.sv
package runpar_pkg;

    localparam int unsigned RP_STATE_W = 2;

    // Reduced machine: the start condition and an even zero run share one code.
    typedef enum logic [RP_STATE_W-1:0] {
        RP_REST  = 2'b00,
        RP_ODD0  = 2'b01,
        RP_ODD1  = 2'b10,
        RP_EVEN1 = 2'b11
    } rp_state_e;

    typedef struct packed {
        rp_state_e st;
        logic      viol;
    } rp_regs_t;

endpackage

// File: rtl/runpar_step.sv
module runpar_step
    import runpar_pkg::*;
(
    input  rp_state_e st_i,
    input  logic      bit_i,
    output rp_state_e st_o,
    output logic      brk_o
);

    // Mealy transition and output table of the reduced machine
    always_comb begin
        st_o  = st_i;
        brk_o = 1'b0;
        unique case (st_i)
            RP_REST: begin
                st_o = bit_i ? RP_ODD1 : RP_ODD0;
            end
            RP_ODD0: begin
                if (bit_i) begin
                    st_o  = RP_ODD1;
                    brk_o = 1'b1;   // zero run closed at odd length
                end else begin
                    st_o  = RP_REST;
                end
            end
            RP_ODD1: begin
                st_o = bit_i ? RP_EVEN1 : RP_ODD0;
            end
            RP_EVEN1: begin
                if (bit_i) begin
                    st_o  = RP_ODD1;
                end else begin
                    st_o  = RP_ODD0;
                    brk_o = 1'b1;   // one run closed at even length
                end
            end
            default: begin
                st_o = RP_REST;
            end
        endcase
    end

endmodule

// File: rtl/runpar_detector.sv
module runpar_detector
    import runpar_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  din,
    input  logic                  din_vld,
    output logic                  viol,
    output logic [RP_STATE_W-1:0] state_code
);

    rp_regs_t  r_d, r_q;
    rp_state_e step_st;
    logic      step_brk;

    runpar_step i_step (
        .st_i  (r_q.st),
        .bit_i (din),
        .st_o  (step_st),
        .brk_o (step_brk)
    );

    always_comb begin
        r_d      = r_q;
        r_d.viol = 1'b0;
        if (din_vld) begin
            r_d.st   = step_st;
            r_d.viol = step_brk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st   <= RP_REST;
            r_q.viol <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign viol       = r_q.viol;
    assign state_code = r_q.st;

endmodule

// File: rtl/runpar_detector_sva.sv
module runpar_detector_sva (
    input logic       clk,
    input logic       rst,
    input logic       din,
    input logic       din_vld,
    input logic       viol,
    input logic [1:0] state_code
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state_code == 2'b00 && !viol));

    // R7
    hold_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !din_vld |=> !viol);

    // R7
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !din_vld |=> $stable(state_code));

    // R3
    odd_zero_end_chk: assert property (@(posedge clk) disable iff (rst)
        (din_vld && din && state_code == 2'b01) |=> viol);

    // R4
    even_one_end_chk: assert property (@(posedge clk) disable iff (rst)
        (din_vld && !din && state_code == 2'b11) |=> viol);

    // R5
    legal_end_chk: assert property (@(posedge clk) disable iff (rst)
        (din_vld && !din && state_code == 2'b10) |=> !viol);

    // R6
    extend_chk: assert property (@(posedge clk) disable iff (rst)
        (din_vld && din && state_code == 2'b10) |=> (!viol && state_code == 2'b11));

endmodule

bind runpar_detector runpar_detector_sva i_runpar_detector_sva (
    .clk        (clk),
    .rst        (rst),
    .din        (din),
    .din_vld    (din_vld),
    .viol       (viol),
    .state_code (state_code)
);

// File: tb/test_runpar_detector.sv
module test_runpar_detector;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       din = 1'b0;
    logic       din_vld = 1'b0;
    logic       viol;
    logic [1:0] state_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // behavioural run-length model
    bit m_started = 1'b0;
    bit m_sym     = 1'b0;
    int m_len     = 0;

    always #5 clk = ~clk;

    runpar_detector i_runpar_detector (
        .clk        (clk),
        .rst        (rst),
        .din        (din),
        .din_vld    (din_vld),
        .viol       (viol),
        .state_code (state_code)
    );

    function automatic logic [1:0] model_code();
        if (!m_started)  return 2'b00;
        if (m_sym == 1'b0) return (m_len % 2 == 1) ? 2'b01 : 2'b00;
        return (m_len % 2 == 1) ? 2'b10 : 2'b11;
    endfunction

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; din_vld = 1'b0;
        @(posedge clk); #1;
        m_started = 1'b0; m_len = 0;
        check("R1 state", state_code, 2'b00);
        check("R1 flag", {1'b0, viol}, 2'b00);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input logic b, input logic v);
        logic  exp_f;
        string tag;
        @(negedge clk);
        din = b; din_vld = v;
        exp_f = 1'b0;
        tag = "R7";
        if (v) begin
            if (!m_started) begin
                m_started = 1'b1; m_sym = b; m_len = 1; tag = "R6";
            end else if (b == m_sym) begin
                m_len++; tag = "R6";
            end else begin
                if (m_sym == 1'b0 && m_len % 2 == 1) begin exp_f = 1'b1; tag = "R3"; end
                else if (m_sym == 1'b1 && m_len % 2 == 0) begin exp_f = 1'b1; tag = "R4"; end
                else tag = "R5";
                m_sym = b; m_len = 1;
            end
        end
        @(posedge clk); #1;
        check({tag, " flag R8"}, {1'b0, viol}, {1'b0, exp_f});
        check({tag, " state R2"}, state_code, model_code());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // directed runs of length 1..4 of each symbol, each closed by the other symbol
        for (int s = 0; s < 2; s++) begin
            for (int len = 1; len <= 4; len++) begin
                for (int k = 0; k < len; k++) send(logic'(s), 1'b1);
                send(logic'(1 - s), 1'b1);
            end
        end
        // back-to-back violations: 1,1 then 0 then 1 (R4 then R3)
        do_reset();
        send(1'b1, 1'b1); send(1'b1, 1'b1); send(1'b0, 1'b1); send(1'b1, 1'b1);
        // alternating single bits
        for (int k = 0; k < 8; k++) send(logic'(k % 2), 1'b1);
        // R9: open run at pause is never judged; valid low holds (R7)
        do_reset();
        send(1'b0, 1'b1);
        for (int k = 0; k < 5; k++) send(1'b1, 1'b0);
        send(1'b0, 1'b1);
        // R9: reset mid-run discards the run
        do_reset();
        send(1'b1, 1'b1); send(1'b1, 1'b1);
        do_reset();
        send(1'b0, 1'b1);
        // random streams with gaps
        for (int k = 0; k < 3000; k++) begin
            send(logic'($urandom_range(0, 1)), logic'($urandom_range(0, 3) != 0));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule